// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one entry from a flat page table held in memory. The entry address is the table base plus the virtual page number times four. The walker sends a single read for that entry. When the data returns, it decodes the entry and answers with either a physical address or a fault code. A fault is either a missing page or a permission violation.

The table base sits in a register that software can rewrite at any time. Pointing it at another table switches the walker to another address space. Only one translation is in flight at a time. The request side stays busy from acceptance until the response has been taken.

Top module: `pt_walker`

## Requirements
- R1: The entry read address is `base + vaddr[31:10] * 4`, computed modulo 2^32. Page offset is `vaddr[9:0]`.
- R2: For a permitted valid entry, the response is `paddr = {pte[21:0], vaddr[9:0]}` with fault code 2'b00.
- R3: If entry bit 31 (valid) is 0, the response is fault code 2'b01 (page fault) with paddr 0, whatever the rights and access type.
- R4: Access codes are 2'b00 load, 2'b01 store and 2'b10 fetch. Rights in entry bits 30:29 are 2'b00 read-only, 2'b01 read/write and 2'b10 execute. A load is allowed on all three rights, a store only on read/write, and a fetch only on execute. A disallowed access on a valid entry gives fault code 2'b10 (protection) with paddr 0.
- R5: Rights 2'b11, or access code 2'b11, on a valid entry gives fault code 2'b10 with paddr 0.
- R6: `req_ready_o` drops in the cycle after acceptance. It stays low until the cycle after the response handshake. `mem_req_o` is a single-cycle pulse in the cycle after acceptance.
- R7: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response and its payload hold steady.
- R8: A base write in the same cycle as acceptance, or in any earlier cycle, sets that walk's entry address. A base write while a walk is outstanding affects only later walks.
- R9: `mem_rvalid_i` is ignored unless the walker is waiting for read data after its request pulse.
- R10: After reset, `req_ready_o` is 1 and `mem_req_o` and `rsp_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 32 | New table base |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access type |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | 32 | Entry byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page table entry |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 2 | 00 none, 01 page fault, 10 protection |

## Verification
Two actions can land in the same clock edge: a base register write and a request acceptance. The bench pulses the base write strobe together with a request and checks that the read address already uses the new base. It also writes the base while a walk is waiting for data and checks that the address issued for that walk is unchanged and the next walk picks up the new value. Separately, a stray read-valid pulse in the same cycle as the request pulse must not complete the walk. The bench checks this by comparing the response with the data returned later.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int PTE_W     = 32;
  localparam int PTE_V_BIT = 31;
  localparam int PTE_R_LO  = 29;

  typedef logic [1:0] acc_t;
  localparam acc_t ACC_LOAD  = 2'b00;
  localparam acc_t ACC_STORE = 2'b01;
  localparam acc_t ACC_FETCH = 2'b10;

  typedef logic [1:0] rights_t;
  localparam rights_t RGT_RO = 2'b00;
  localparam rights_t RGT_RW = 2'b01;
  localparam rights_t RGT_EX = 2'b10;

  typedef logic [1:0] fault_t;
  localparam fault_t FLT_NONE = 2'b00;
  localparam fault_t FLT_PAGE = 2'b01;
  localparam fault_t FLT_PROT = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] eff_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (we_i) base_q <= wdata_i;
  end

  // same-cycle write is forwarded to a request accepted on that edge
  assign eff_o = we_i ? wdata_i : base_q;
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int AW        = 32,
  parameter int VPN_W     = 22,
  parameter int PTE_BYTES = 4
) (
  input  logic [AW-1:0]    base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [AW-1:0]    addr_o
);
  localparam int SHIFT = $clog2(PTE_BYTES);

  logic [AW-1:0] idx_ext;
  assign idx_ext = AW'(vpn_i);
  assign addr_o  = base_i + (idx_ext << SHIFT);
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import pt_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int PA_W  = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  acc_t             acc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output fault_t           fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int PPN_W = PA_W - OFS_W;

  logic    valid;
  rights_t rgt;
  logic    allowed;

  assign valid = pte_i[PTE_V_BIT];
  assign rgt   = pte_i[PTE_R_LO +: 2];

  always_comb begin
    allowed = 1'b0;
    unique case (acc_i)
      ACC_LOAD:  allowed = (rgt != 2'b11);
      ACC_STORE: allowed = (rgt == RGT_RW);
      ACC_FETCH: allowed = (rgt == RGT_EX);
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!valid) begin
      fault_o = FLT_PAGE;
      paddr_o = '0;
    end else if (!allowed) begin
      fault_o = FLT_PROT;
      paddr_o = '0;
    end else begin
      fault_o = FLT_NONE;
      paddr_o = {pte_i[PPN_W-1:0], ofs_i};
    end
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFS_W = 10,
  parameter int PA_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [OFS_W-1:0] req_ofs_i,
  input  acc_t             req_acc_i,
  input  logic [AW-1:0]    entry_addr_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  output logic [OFS_W-1:0] ofs_o,
  output acc_t             acc_o,
  input  fault_t           chk_fault_i,
  input  logic [PA_W-1:0]  chk_paddr_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output fault_t           rsp_fault_o
);
  walk_st_e         st_q, st_d;
  logic [AW-1:0]    addr_q;
  logic [OFS_W-1:0] ofs_q;
  acc_t             acc_q;
  logic [PA_W-1:0]  paddr_q;
  fault_t           fault_q;
  logic             accept, capture;

  assign accept  = req_valid_i && (st_q == ST_IDLE);
  assign capture = mem_rvalid_i && (st_q == ST_WAIT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid_i) st_d = ST_RESP;
      ST_RESP:  if (rsp_ready_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ofs_q  <= '0;
      acc_q  <= ACC_LOAD;
    end else if (accept) begin
      addr_q <= entry_addr_i;
      ofs_q  <= req_ofs_i;
      acc_q  <= req_acc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else if (capture) begin
      paddr_q <= chk_paddr_i;
      fault_q <= chk_fault_i;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_ISSUE);
  assign mem_addr_o  = addr_q;
  assign ofs_o       = ofs_q;
  assign acc_o       = acc_q;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int AW        = 32,
  parameter int OFS_W     = 10,
  parameter int PTE_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [AW-1:0]     base_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic [1:0]        rsp_fault_o
);
  localparam int VPN_W = VA_W - OFS_W;

  logic [AW-1:0]    base_eff;
  logic [AW-1:0]    entry_addr;
  logic [OFS_W-1:0] ofs_q;
  acc_t             acc_q;
  fault_t           chk_fault;
  logic [PA_W-1:0]  chk_paddr;

  pt_base_reg #(.AW(AW)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .eff_o   (base_eff)
  );

  pt_addr_gen #(.AW(AW), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)) u_addr (
    .base_i (base_eff),
    .vpn_i  (req_vaddr_i[VA_W-1:OFS_W]),
    .addr_o (entry_addr)
  );

  pt_pte_check #(.OFS_W(OFS_W), .PA_W(PA_W)) u_chk_pte (
    .pte_i   (mem_rdata_i),
    .acc_i   (acc_q),
    .ofs_i   (ofs_q),
    .fault_o (chk_fault),
    .paddr_o (chk_paddr)
  );

  pt_walk_ctrl #(.AW(AW), .OFS_W(OFS_W), .PA_W(PA_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_ofs_i    (req_vaddr_i[OFS_W-1:0]),
    .req_acc_i    (req_acc_i),
    .entry_addr_i (entry_addr),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .ofs_o        (ofs_q),
    .acc_o        (acc_q),
    .chk_fault_i  (chk_fault),
    .chk_paddr_i  (chk_paddr),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic            mem_req_o,
  input logic            mem_rvalid_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic [1:0]      rsp_fault_o
);
  logic [OFS_W-1:0] ofs_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ofs_seen <= '0;
    else if (req_valid_i && req_ready_o) ofs_seen <= req_vaddr_i[OFS_W-1:0];
  end

  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && mem_req_o));

  // R6
  mem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R6
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  // R7
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  // R2
  ofs_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'b00) |-> (rsp_paddr_o[OFS_W-1:0] == ofs_seen));

  // R3
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'b00) |-> (rsp_paddr_o == '0));

  // R6
  rsp_after_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(mem_rvalid_i));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_walker_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_vaddr_i  (req_vaddr_i),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_fault_o  (rsp_fault_o)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] cur_base = '0;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic [1:0] acc);
    logic [1:0] r;
    r = pte[30:29];
    if (!pte[31]) return 2'b01;
    if (acc == 2'b00 && r != 2'b11) return 2'b00;
    if (acc == 2'b01 && r == 2'b01) return 2'b00;
    if (acc == 2'b10 && r == 2'b10) return 2'b00;
    return 2'b10;
  endfunction

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = b;
  endtask

  // one walk; wr_acc: base write with acceptance, wr_mid: base write while waiting,
  // spur: stray read-valid during the request pulse, bp: cycles of response backpressure
  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] pte,
                      input int lat, input int bp, input bit wr_acc, input bit wr_mid,
                      input logic [31:0] nb, input bit spur);
    logic [31:0] exp_addr, exp_pa;
    logic [1:0]  ef;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    if (wr_acc) begin base_we = 1'b1; base_wdata = nb; cur_base = nb; end
    rsp_ready = (bp == 0);
    exp_addr = cur_base + {va[31:10], 2'b00};
    @(negedge clk);
    req_valid = 1'b0; base_we = 1'b0;
    chk("R6 mem_req pulse", {63'd0, mem_req}, 64'd1);
    chk("R6 ready low", {63'd0, req_ready}, 64'd0);
    chk(wr_acc ? "R8 same-cycle base" : "R1 entry addr", {32'd0, mem_addr}, {32'd0, exp_addr});
    if (spur) begin mem_rvalid = 1'b1; mem_rdata = 32'h0; end
    @(negedge clk);
    mem_rvalid = 1'b0;
    if (spur) chk("R9 stray rvalid ignored", {63'd0, rsp_valid}, 64'd0);
    chk("R6 single pulse", {63'd0, mem_req}, 64'd0);
    for (int i = 0; i < lat; i++) begin
      if (wr_mid && i == 0) begin base_we = 1'b1; base_wdata = nb; end
      @(negedge clk);
      if (wr_mid && i == 0) begin base_we = 1'b0; cur_base = nb; end
    end
    mem_rvalid = 1'b1; mem_rdata = pte;
    @(negedge clk);
    mem_rvalid = 1'b0;
    ef = exp_fault(pte, acc);
    exp_pa = (ef == 2'b00) ? {pte[21:0], va[9:0]} : 32'd0;
    chk("R6 rsp valid", {63'd0, rsp_valid}, 64'd1);
    chk(ef == 2'b01 ? "R3 fault" : (pte[30:29] == 2'b11 || acc == 2'b11) ? "R5 fault" :
        ef == 2'b10 ? "R4 fault" : "R2 fault", {62'd0, rsp_fault}, {62'd0, ef});
    chk(ef == 2'b00 ? "R2 paddr" : "R4 paddr zero", {32'd0, rsp_paddr}, {32'd0, exp_pa});
    if (wr_mid) chk("R8 mid-walk addr kept", {32'd0, mem_addr}, {32'd0, exp_addr});
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk("R7 rsp held", {30'd0, rsp_valid, rsp_fault, req_ready},
          {30'd0, 1'b1, ef, 1'b0});
      chk("R7 paddr held", {32'd0, rsp_paddr}, {32'd0, exp_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R6 ready after handshake", {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R10 reset idle", {62'd0, mem_req, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    set_base(32'h0010_0000);

    // R9: read-valid while idle has no effect
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h8000_0001;
    repeat (2) @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R9 idle rvalid ignored", {61'd0, rsp_valid, mem_req, req_ready}, 64'd1);

    // sweep valid x rights x access (R2 R3 R4 R5)
    for (int v = 0; v < 2; v++)
      for (int r = 0; r < 4; r++)
        for (int a = 0; a < 4; a++) begin
          int idx;
          logic [21:0] vpn, ppn;
          logic [9:0]  ofs;
          idx = v * 16 + r * 4 + a;
          vpn = 22'(idx * 131071 + 5);
          ofs = 10'(idx * 29 + 3);
          ppn = 22'(idx * 1234) ^ 22'h2AAAA;
          walk({vpn, ofs}, 2'(a), {v[0], r[1:0], 7'(idx), ppn}, idx % 4, 0, 0, 0, '0, 0);
        end

    // R1: address wraps modulo 2^32
    set_base(32'hFFFF_F000);
    walk({22'h3FFFFF, 10'h155}, 2'b00, {1'b1, 2'b01, 7'd0, 22'h12345}, 1, 0, 0, 0, '0, 0);
    walk({22'h000001, 10'h3FF}, 2'b10, {1'b1, 2'b10, 7'd0, 22'h3FFFFF}, 0, 0, 0, 0, '0, 0);

    // R8: base written in the accepting cycle, then while a walk waits
    walk({22'h00ABC, 10'h011}, 2'b01, {1'b1, 2'b01, 7'd0, 22'h00777}, 2, 0, 1, 0, 32'h2000_0000, 0);
    walk({22'h00ABC, 10'h011}, 2'b01, {1'b1, 2'b01, 7'd0, 22'h00778}, 3, 0, 0, 1, 32'h3000_0400, 0);
    walk({22'h00ABC, 10'h022}, 2'b00, {1'b1, 2'b00, 7'd0, 22'h00779}, 0, 0, 0, 0, '0, 0);

    // R9 stray rvalid in request cycle; R7 backpressure
    walk({22'h01234, 10'h2A0}, 2'b10, {1'b1, 2'b10, 7'd0, 22'h0BEEF}, 1, 0, 0, 0, '0, 1);
    walk({22'h05555, 10'h0F0}, 2'b00, {1'b1, 2'b01, 7'd0, 22'h1ABCD}, 0, 3, 0, 0, '0, 0);
    walk({22'h05556, 10'h0F1}, 2'b01, {1'b0, 2'b01, 7'd0, 22'h1ABCD}, 2, 2, 0, 0, '0, 1);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule